// File: doc/BRIEF.md
# One-Bit Quadrature Mixer and Pair Counter

This block takes a single-bit, oversampled RF stream that arrives at one bit per system clock and mixes it down to baseband in two quadrature paths. Each path has its own one-bit local oscillator, which is the most significant bit of a 32-bit phase accumulator. The mixing is a plain XOR of the RF bit with the oscillator bit. It uses no multiplier and produces no multi-bit product.

Each path reads its mixed bits two at a time. When both bits of a pair are zero, the path's "negative" counter counts down by one. When both are one, the "positive" counter counts down by one. Any other pair changes neither counter. A sample strobe, applied at twice the output IQ rate, copies all four counters to the outputs and restarts them from zero. A downstream stage takes the differences between successive values, so counter wrap does no harm.

The oscillators replay a fixed-length bit pattern. At each pattern boundary both phases return to their starting offsets, and the tuning step applied from the input word is loaded at that point only. A frequency rounded to the pattern grid therefore repeats without a seam.

Top module: `bitstream_quad_mixer`

## Requirements
- R1: While rst_n is low, all four count outputs read 0, cnt_valid is low, both phases sit at their start offsets, the active step is 0, the pattern position is 0 and pair alignment restarts, so the first bit after reset is the first bit of a pair.
- R2: In each clock, each oscillator bit equals bit 31 of its 32-bit phase. Within a pattern, the phase advances by the active step in each clock.
- R3: The cosine (I) phase starts at 0xC0000000 and the sine (Q) phase starts at 0. With the active step at 0 after reset, the I oscillator bit is constant 1 and the Q oscillator bit is constant 0.
- R4: A pattern lasts 2^PATTERN_LOG2 clocks, counted from reset. In the last clock of each pattern, step_word is loaded as the new active step and both phases return to their start offsets. A change of step_word at any other time has no effect until that boundary.
- R5: The I mixed bit is rf_bit XOR the cosine bit, and the Q mixed bit is rf_bit XOR the sine bit.
- R6: Mixed bits form consecutive pairs, earlier bit first, aligned from reset and unaffected by the strobe. Pair 00 decrements the negative counter, pair 11 decrements the positive counter, and pairs 01 and 10 change nothing.
- R7: When sample_stb is high in a clock, then in the next clock cnt_valid is high for one cycle and each output holds its counter's value, including a pair that completes in the strobe clock. The counter restarts at 0 for the clock that follows. Outputs hold between strobes, and back-to-back strobes work.
- R8: The counters are 32 bits wide and wrap modulo 2^32, so one decrement from 0 reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one RF bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rf_bit | input | 1 | Oversampled one-bit RF sample |
| step_word | input | 32 | Phase increment per clock, loaded at pattern boundary |
| sample_stb | input | 1 | Latch-and-clear strobe, twice the IQ rate |
| i_neg_cnt | output | 32 | Latched I counter for 00 pairs |
| i_pos_cnt | output | 32 | Latched I counter for 11 pairs |
| q_neg_cnt | output | 32 | Latched Q counter for 00 pairs |
| q_pos_cnt | output | 32 | Latched Q counter for 11 pairs |
| cnt_valid | output | 1 | One-cycle pulse: new latched counts present |

## Verification
The assertions assume that rst_n is released in step with the clock and that sample_stb and rf_bit are clean, with no unknown values, at every rising edge once reset is released. They also assume that step_word is stable across the edge where a boundary loads it. The bench drives every input on the falling edge, so each value is settled a half period before it is sampled. Inputs are held low and zero during reset. The strobe patterns include a strobe in the first clock after reset, strobes in consecutive clocks, and long gaps, so that every pair alignment relative to the strobe occurs.

// File: rtl/bqm_pkg.sv
package bqm_pkg;
  // Start offsets in quarter turns of the phase circle.
  localparam int unsigned COS_QUARTERS = 3;
  localparam int unsigned SIN_QUARTERS = 0;
  localparam int unsigned NUM_CH       = 2;
endpackage

// File: rtl/bqm_lo_nco.sv
module bqm_lo_nco #(
  parameter int unsigned PHASE_W       = 32,
  parameter int unsigned START_QUARTERS = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] step,
  input  logic               restart,
  output logic               lo_bit
);
  localparam logic [PHASE_W-1:0] START = PHASE_W'(START_QUARTERS) << (PHASE_W - 2);

  logic [PHASE_W-1:0] phase_q, phase_d;

  always_comb begin
    if (restart) phase_d = START;
    else         phase_d = phase_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= START;
    else        phase_q <= phase_d;
  end

  assign lo_bit = phase_q[PHASE_W-1];

  // R4
  restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == START));
endmodule

// File: rtl/bqm_pair_counter.sv
module bqm_pair_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mix_bit,
  input  logic             sample,
  output logic [CNT_W-1:0] neg_out,
  output logic [CNT_W-1:0] pos_out
);
  logic             half_q, half_d;
  logic             first_q, first_d;
  logic [CNT_W-1:0] neg_q, neg_d, pos_q, pos_d;
  logic [CNT_W-1:0] neg_live, pos_live;
  logic [CNT_W-1:0] neg_out_d, pos_out_d;
  logic             neg_dec, pos_dec;

  always_comb begin
    neg_dec   = half_q & ~first_q & ~mix_bit;
    pos_dec   = half_q &  first_q &  mix_bit;
    neg_live  = neg_q - CNT_W'(neg_dec);
    pos_live  = pos_q - CNT_W'(pos_dec);
    half_d    = ~half_q;
    first_d   = mix_bit;
    neg_d     = sample ? '0 : neg_live;
    pos_d     = sample ? '0 : pos_live;
    neg_out_d = sample ? neg_live : neg_out;
    pos_out_d = sample ? pos_live : pos_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      first_q <= 1'b0;
      neg_q   <= '0;
      pos_q   <= '0;
      neg_out <= '0;
      pos_out <= '0;
    end else begin
      half_q  <= half_d;
      first_q <= first_d;
      neg_q   <= neg_d;
      pos_q   <= pos_d;
      if (sample) begin
        neg_out <= neg_out_d;
        pos_out <= pos_out_d;
      end
    end
  end

  // R6
  mixed_pair_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_q && (first_q != mix_bit) && !sample) |=> ($stable(neg_q) && $stable(pos_q)));

  // R6
  one_counter_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> ($stable(neg_q) || $stable(pos_q)));

  // R7
  restart_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> (neg_q == '0 && pos_q == '0));

  // R7
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> ($stable(neg_out) && $stable(pos_out)));
endmodule

// File: rtl/bitstream_quad_mixer.sv
module bitstream_quad_mixer #(
  parameter int unsigned PHASE_W      = 32,
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned PATTERN_LOG2 = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rf_bit,
  input  logic [PHASE_W-1:0] step_word,
  input  logic               sample_stb,
  output logic [CNT_W-1:0]   i_neg_cnt,
  output logic [CNT_W-1:0]   i_pos_cnt,
  output logic [CNT_W-1:0]   q_neg_cnt,
  output logic [CNT_W-1:0]   q_pos_cnt,
  output logic               cnt_valid
);
  import bqm_pkg::*;

  localparam logic [PATTERN_LOG2-1:0] LAST_POS = '1;

  logic [PATTERN_LOG2-1:0] pos_q, pos_d;
  logic [PHASE_W-1:0]      step_q, step_d;
  logic                    boundary;
  logic                    valid_d;
  logic [NUM_CH-1:0]       lo_bits, mix_bits;
  logic [CNT_W-1:0]        neg_arr [NUM_CH];
  logic [CNT_W-1:0]        pos_arr [NUM_CH];

  always_comb begin
    boundary = (pos_q == LAST_POS);
    pos_d    = pos_q + 1'b1;
    step_d   = boundary ? step_word : step_q;
    valid_d  = sample_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      step_q    <= '0;
      cnt_valid <= 1'b0;
    end else begin
      pos_q     <= pos_d;
      cnt_valid <= valid_d;
      if (boundary) step_q <= step_d;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int unsigned QUARTERS = (ch == 0) ? COS_QUARTERS : SIN_QUARTERS;

    bqm_lo_nco #(
      .PHASE_W        (PHASE_W),
      .START_QUARTERS (QUARTERS)
    ) u_nco (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step_q),
      .restart (boundary),
      .lo_bit  (lo_bits[ch])
    );

    assign mix_bits[ch] = rf_bit ^ lo_bits[ch];

    bqm_pair_counter #(
      .CNT_W (CNT_W)
    ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .mix_bit (mix_bits[ch]),
      .sample  (sample_stb),
      .neg_out (neg_arr[ch]),
      .pos_out (pos_arr[ch])
    );
  end

  assign i_neg_cnt = neg_arr[0];
  assign i_pos_cnt = pos_arr[0];
  assign q_neg_cnt = neg_arr[1];
  assign q_pos_cnt = pos_arr[1];

  // R7
  valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> cnt_valid);

  // R7
  valid_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> !cnt_valid);

  // R4
  step_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(step_q));

  // R4
  step_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (step_q == $past(step_word)));
endmodule

// File: tb/bitstream_quad_mixer_tb_top.sv
`timescale 1ns/1ps
module bitstream_quad_mixer_tb_top;
  localparam int PL   = 5;
  localparam int PLEN = 1 << PL;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rf_bit = 1'b0;
  logic        sample_stb = 1'b0;
  logic [31:0] step_word = 32'd0;
  logic [31:0] i_neg_cnt, i_pos_cnt, q_neg_cnt, q_pos_cnt;
  logic        cnt_valid;

  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  bitstream_quad_mixer #(.PATTERN_LOG2(PL)) dut_i (
    .clk(clk), .rst_n(rst_n), .rf_bit(rf_bit), .step_word(step_word),
    .sample_stb(sample_stb), .i_neg_cnt(i_neg_cnt), .i_pos_cnt(i_pos_cnt),
    .q_neg_cnt(q_neg_cnt), .q_pos_cnt(q_pos_cnt), .cnt_valid(cnt_valid));

  // Behavioural reference: index 0 = I (cosine), 1 = Q (sine)
  int unsigned m_pos;
  bit [31:0]   m_step;
  bit [31:0]   m_ph [2];
  bit          m_half;
  bit          m_first [2];
  bit [31:0]   m_neg [2], m_posc [2], m_oneg [2], m_opos [2];
  bit          m_valid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_step = 0; m_ph[0] = 32'hC000_0000; m_ph[1] = 0;
      m_half = 0; m_valid = 0;
      for (int c = 0; c < 2; c++) begin
        m_first[c] = 0; m_neg[c] = 0; m_posc[c] = 0; m_oneg[c] = 0; m_opos[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit mx;
        mx = rf_bit ^ m_ph[c][31];
        if (m_half && !m_first[c] && !mx) m_neg[c] = m_neg[c] - 1;
        if (m_half &&  m_first[c] &&  mx) m_posc[c] = m_posc[c] - 1;
        m_first[c] = mx;
        if (sample_stb) begin
          m_oneg[c] = m_neg[c]; m_opos[c] = m_posc[c];
          m_neg[c] = 0; m_posc[c] = 0;
        end
      end
      m_half  = !m_half;
      m_valid = sample_stb;
      if (m_pos == PLEN - 1) begin
        m_pos = 0; m_step = step_word;
        m_ph[0] = 32'hC000_0000; m_ph[1] = 0;
      end else begin
        m_pos++;
        m_ph[0] = m_ph[0] + m_step; m_ph[1] = m_ph[1] + m_step;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(cnt_valid === m_valid, "cnt_valid", {31'd0, cnt_valid}, {31'd0, m_valid});
    chk(i_neg_cnt === m_oneg[0], "i_neg_cnt", i_neg_cnt, m_oneg[0]);
    chk(i_pos_cnt === m_opos[0], "i_pos_cnt", i_pos_cnt, m_opos[0]);
    chk(q_neg_cnt === m_oneg[1], "q_neg_cnt", q_neg_cnt, m_oneg[1]);
    chk(q_pos_cnt === m_opos[1], "q_pos_cnt", q_pos_cnt, m_opos[1]);
  endtask

  // mode: 0 zeros, 1 ones, 2 alternating, 3 random; stb_per 0 = strobe every cycle
  task automatic run(input int cycles, input int mode, input int stb_per, input logic [31:0] step);
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      compare();
      step_word = step;
      case (mode)
        0: rf_bit = 1'b0;
        1: rf_bit = 1'b1;
        2: rf_bit = n[0];
        default: rf_bit = 1'($urandom);
      endcase
      sample_stb = (stb_per == 0) ? 1'b1 : (n % stb_per == stb_per - 1);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    tag = "R1";
    chk(cnt_valid === 1'b0, "valid in reset", {31'd0, cnt_valid}, 32'd0);
    chk(i_neg_cnt === 32'd0, "i_neg in reset", i_neg_cnt, 32'd0);
    chk(q_pos_cnt === 32'd0, "q_pos in reset", q_pos_cnt, 32'd0);
    rst_n = 1'b1;
    sample_stb = 1'b1;                          // strobe in first clock
    // R3: first pattern runs at step 0, I bit 1, Q bit 0; R8 wrap from 0
    tag = "R3 R8";
    run(PLEN - 2, 0, 6, 32'h1357_9BDF);
    // R2: stepping phase, random data
    tag = "R2";
    run(400, 3, 10, 32'h1357_9BDF);
    // R4: step changes mid-pattern, applied only at boundaries
    tag = "R4";
    for (int k = 0; k < 8; k++) run(PLEN / 2 + 3, 3, 7, 32'h0800_0000 * (k + 1) + 32'd5);
    // R5: constant ones through the mixer
    tag = "R5";
    run(300, 1, 9, 32'h2000_0000);
    // R6: step 0 then alternating data gives only mixed pairs
    tag = "R6";
    run(2 * PLEN, 0, 5, 32'd0);
    run(200, 2, 8, 32'd0);
    run(200, 3, 3, 32'd0);
    // R7: strobe every clock, then odd spacing to shift pair alignment
    tag = "R7";
    run(100, 3, 0, 32'h0F0F_0F0F);
    run(300, 3, 5, 32'h7777_7777);
    // R8: long windows of decrements wrap below zero
    tag = "R8";
    run(600, 0, 150, 32'h0000_0000);
    @(negedge clk);
    compare();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule